// File: doc/BRIEF.md
# Free-Running Idle Wake-Up Timer

This block is a 16-bit down counter that starts at all ones when reset is released and then runs without stopping. It steps once for each instruction-cycle tick it receives. No processor path reads or writes the count. It is a time base for low-power operation. Whenever bit 12 of the count changes value, in either direction, the block issues a one-cycle strobe. Other logic, such as a wake-up sequencer, a watchdog or a start-up delay, can use that strobe directly.

Each strobe also sets a sticky pending flag. The flag holds until a clear pulse arrives from the register interface. An enable flag, loaded through a write strobe, gates the pending flag onto the interrupt request. Bit 12 changes once every 4096 ticks, so with a 1 µs instruction cycle the flag is raised every 4.096 ms.

Top module: `idle_tmr`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the count is 16'hFFFF, the pending flag and the enable flag are 0, and `toggle_o`, `pend_o` and `irq_o` are all 0.
- R2: The count drops by one on each rising clock edge where `tick_i` is 1 and holds its value on every other edge. It wraps from 16'h0000 to 16'hFFFF.
- R3: Bit 12 first changes after exactly 4096 ticks from reset, and again after every further 4096 ticks, including across the wrap.
- R4: `toggle_o` is 1 for exactly one clock cycle: the cycle after the edge at which bit 12 of the count changed. Otherwise it is 0.
- R5: `pend_o` becomes 1 on the edge that ends a cycle in which `toggle_o` is 1, whatever the enable flag holds.
- R6: Once set, `pend_o` stays 1 until `pend_clr_i` is 1 at a rising edge. It then reads 0 from the next cycle.
- R7: When `toggle_o` and `pend_clr_i` are both 1 in the same cycle, `pend_o` is 1 after that edge: the set wins.
- R8: When `en_wr_i` is 1 at a rising edge, the enable flag takes the value of `en_val_i`. Otherwise the flag holds. `irq_o` equals the AND of the enable flag and `pend_o` in the same cycle.
- R9: While the enable flag is 0, `irq_o` stays 0 even with `pend_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per instruction cycle; steps the counter |
| en_wr_i | input | 1 | Write strobe for the interrupt enable flag |
| en_val_i | input | 1 | Value loaded into the enable flag on a write |
| pend_clr_i | input | 1 | Pulse that clears the pending flag |
| toggle_o | output | 1 | One-cycle strobe on each change of count bit 12 |
| pend_o | output | 1 | Sticky pending flag |
| irq_o | output | 1 | Interrupt request: enable AND pending |

## Verification
The counter is first driven with a tick on four cycles out of five, then with a tick on every cycle. A tap period that still comes out at 4096 ticks under gaps shows that the count holds between ticks instead of running on the clock. Clear pulses land both in quiet cycles and in the very cycle of a strobe, which separates plain clearing from the set-wins collision. The enable flag is written low, high and low again while the pending flag is set, which shows that masking only hides the request and never loses the flag. The run goes past the 0-to-FFFF wrap, so the strobe at the wrap is also checked.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

    localparam int unsigned CNT_W   = 16;
    localparam int unsigned TAP_BIT = 12;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_INIT = '1;

    typedef struct packed {
        logic en;
        logic pend;
    } irq_state_t;

    localparam irq_state_t IRQ_STATE_INIT = '{en: 1'b0, pend: 1'b0};

    function automatic irq_state_t irq_next(
        input irq_state_t cur,
        input logic       set_ev,
        input logic       clr_ev,
        input logic       en_wr,
        input logic       en_val
    );
        irq_state_t n;
        n = cur;
        if (set_ev)      n.pend = 1'b1;
        else if (clr_ev) n.pend = 1'b0;
        if (en_wr)       n.en   = en_val;
        return n;
    endfunction

endpackage

// File: rtl/idle_tmr_counter.sv
module idle_tmr_counter
    import idle_tmr_pkg::*;
#(
    parameter int unsigned W   = CNT_W,
    parameter int unsigned TAP = TAP_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic tap_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '1;
        else if (tick_i) cnt_q <= cnt_q - 1'b1;
    end

    assign tap_o = cnt_q[TAP];

    // R2: one step down per tick
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: no tick, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

    // R1: reset value
    a_r1_init: assert property (@(posedge clk)
        rst |=> (cnt_q == '1));

endmodule

// File: rtl/idle_tmr_edge.sv
module idle_tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic tap_i,
    output logic toggle_o
);
    logic tap_q;

    always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b1;
        else     tap_q <= tap_i;
    end

    assign toggle_o = tap_i ^ tap_q;

    // R4: strobe lasts one cycle
    a_r4_single: assert property (@(posedge clk) disable iff (rst)
        toggle_o |=> !toggle_o);

endmodule

// File: rtl/idle_tmr_irq.sv
module idle_tmr_irq
    import idle_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    output logic pend_o,
    output logic irq_o
);
    irq_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= IRQ_STATE_INIT;
        else     st_q <= irq_next(st_q, set_i, clr_i, en_wr_i, en_val_i);
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.en & st_q.pend;

    // R5 and R7: a strobe always sets the flag, even when a clear arrives too
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
        set_i |=> pend_o);

    // R6: a clear with no strobe empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !pend_o);

    // R6: the flag holds when there is neither strobe nor clear
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(pend_o));

    // R9: enable written low keeps the request low
    a_r9_mask: assert property (@(posedge clk) disable iff (rst)
        (en_wr_i && !en_val_i) |=> !irq_o);

endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
    import idle_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic pend_clr_i,
    output logic toggle_o,
    output logic pend_o,
    output logic irq_o
);
    logic tap;

    idle_tmr_counter #(.W(CNT_W), .TAP(TAP_BIT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .tap_o  (tap)
    );

    idle_tmr_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .tap_i    (tap),
        .toggle_o (toggle_o)
    );

    idle_tmr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (toggle_o),
        .clr_i    (pend_clr_i),
        .en_wr_i  (en_wr_i),
        .en_val_i (en_val_i),
        .pend_o   (pend_o),
        .irq_o    (irq_o)
    );

    // R8: a request needs a pending flag behind it
    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend_o);

    // R1: everything quiet right after reset
    a_r1_quiet: assert property (@(posedge clk)
        rst |=> (!pend_o && !irq_o && !toggle_o));

endmodule

// File: tb/idle_tmr_bench.sv
`timescale 1ns/1ps
module idle_tmr_bench;

    localparam int NCYC = 80000;
    localparam int PER  = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0, en_wr_i = 1'b0, en_val_i = 1'b0, pend_clr_i = 1'b0;
    logic toggle_o, pend_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    int unsigned m_cnt = 32'hFFFF;
    bit m_tapq = 1'b1;
    bit m_pend = 1'b0;
    bit m_en   = 1'b0;
    int ticks  = 0;
    int last_tog_tick = 0;
    int n_tog = 0;
    int n_coll = 0;

    always #10 clk = ~clk;

    idle_tmr u_idle_tmr (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_wr_i(en_wr_i),
        .en_val_i(en_val_i), .pend_clr_i(pend_clr_i),
        .toggle_o(toggle_o), .pend_o(pend_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        bit exp_tog;
        bit t, w, v, c;
        // reset phase: R1
        repeat (3) @(negedge clk);
        chk("R1 pend during reset", pend_o, 1'b0);
        chk("R1 irq during reset", irq_o, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            exp_tog = (((m_cnt >> 12) & 1) != m_tapq);
            if (cyc == 0) begin
                chk("R1 toggle after reset", toggle_o, 1'b0);
                chk("R1 pend after reset", pend_o, 1'b0);
                chk("R1 irq after reset", irq_o, 1'b0);
            end
            chk("R4 toggle strobe", toggle_o, exp_tog);
            chk("R5/R6/R7 pending flag", pend_o, m_pend);
            chk("R8/R9 irq", irq_o, m_en & m_pend);
            if (exp_tog) begin
                // R3: spacing of tap changes in ticks (includes the wrap)
                chk_int("R3 tap period", ticks - last_tog_tick, PER);
                last_tog_tick = ticks;
                n_tog++;
            end
            if (cyc > 0 && !m_en && m_pend) chk("R9 masked request", irq_o, 1'b0);

            // stimulus
            if (cyc < 15000) t = (cyc % 5 != 4);
            else             t = 1'b1;
            w = 1'b0; v = 1'b0;
            if (cyc == 15000) begin w = 1'b1; v = 1'b1; end
            if (cyc == 40000) begin w = 1'b1; v = 1'b0; end
            if (cyc == 50000) begin w = 1'b1; v = 1'b1; end
            if (cyc == 70000) begin w = 1'b1; v = 1'b0; end
            c = (cyc % 2000 == 1000);
            // R7: clear aimed at every other strobe
            if (exp_tog && (n_tog % 2 == 0)) begin
                c = 1'b1;
                n_coll++;
            end
            tick_i = t; en_wr_i = w; en_val_i = v; pend_clr_i = c;

            @(posedge clk);
            // model update from the values before the edge
            if (exp_tog)  m_pend = 1'b1;
            else if (c)   m_pend = 1'b0;
            if (w)        m_en = v;
            m_tapq = ((m_cnt >> 12) & 1);
            if (t) begin
                m_cnt = (m_cnt - 1) & 32'hFFFF;
                ticks++;
            end
        end
        @(negedge clk);
        // R2: the wrap was crossed, and strobes came at the counts the model expects
        chk_int("R2 ticks past wrap", (ticks > 65536) ? 1 : 0, 1);
        chk_int("R3 strobe count", n_tog, ticks / PER);
        chk_int("R7 collisions exercised", (n_coll > 3) ? 1 : 0, 1);
        finish_up();
    end

endmodule